// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Rounding and Clamping

This block multiplies two signed two's-complement operands that share a single fixed-point format. The format is given by two parameters: the total word width `WIDTH`, and `FRAC`, the number of bits below the binary point. The product is formed at double width, so the multiply itself cannot lose information. The product is then brought back to the operand format by an arithmetic right shift of `FRAC` bits. Before the shift, half an output LSB can optionally be added, which gives round-to-nearest instead of round-toward-minus-infinity.

The rescaled value may not fit in `WIDTH` signed bits. In that case the block either clamps it to the nearest signed rail or keeps its low `WIDTH` bits (two's-complement wrap), as chosen by a per-operation input. A flag reports that the value left the range.

The result and the flag are registered. A strobe on `in_valid` appears as a strobe on `out_valid` one clock later. There is no back-pressure.

Top module: `fxp_mul_rs`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `ovf` and `result` are all 0.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high. The result of the operand pair sampled with that strobe is presented in the same cycle.
- R3: With `round_en`=0 the rescaled value is floor(a*b / 2^FRAC), an arithmetic shift that drops the low FRAC bits. For negative products this rounds toward minus infinity.
- R4: With `round_en`=1 the rescaled value is floor((a*b + 2^(FRAC-1)) / 2^FRAC). It is never more than one LSB above the value of R3. When FRAC=0 both modes give a*b.
- R5: With `sat_en`=1, a rescaled value above 2^(WIDTH-1)-1 gives `result` = 2^(WIDTH-1)-1 and `ovf`=1.
- R6: With `sat_en`=1, a rescaled value below -2^(WIDTH-1) gives `result` = -2^(WIDTH-1) and `ovf`=1.
- R7: With `sat_en`=0, an out-of-range rescaled value gives `result` equal to its low WIDTH bits, and `ovf`=1.
- R8: A rescaled value inside [-2^(WIDTH-1), 2^(WIDTH-1)-1] is output unchanged with `ovf`=0, whatever `sat_en` is. This includes both exact rails.
- R9: In a cycle after `in_valid` was low, `result` and `ovf` keep their previous values, whatever the operands and mode inputs do.
- R10: Elaboration stops with an error unless WIDTH >= 2 and 0 <= FRAC < WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode inputs are sampled this cycle |
| a | input | WIDTH | Signed operand, FRAC fractional bits |
| b | input | WIDTH | Signed operand, FRAC fractional bits |
| round_en | input | 1 | 1: round to nearest (half LSB added); 0: truncate |
| sat_en | input | 1 | 1: clamp to signed rails; 0: wrap |
| out_valid | output | 1 | Result of the previous cycle's strobe is present |
| result | output | WIDTH | Signed product in the operand format |
| ovf | output | 1 | Rescaled value was outside the signed WIDTH range |

## Verification
The bench builds two instances. The first uses WIDTH=8 and FRAC=3, the Q4.3 format. In that format an 8-bit operand space reaches both rails exactly, the case where rounding alone pushes a value past the top rail, negative values that truncate toward minus infinity, and the most negative operand squared. The second uses WIDTH=6 and FRAC=0, which selects the no-rounding branch of the scaler, so that integer products exercise wrap and clamp with no fractional bits at all. Random operands on both instances are compared with a wide-integer model of the requirements.

// File: rtl/fxp_mul_pkg.sv
package fxp_mul_pkg;

   typedef enum logic [0:0] {
      RND_TRUNC   = 1'b0,
      RND_NEAREST = 1'b1
   } rnd_mode_e;

   typedef enum logic [0:0] {
      OVF_WRAP  = 1'b0,
      OVF_CLAMP = 1'b1
   } ovf_mode_e;

   // width of the rescaled intermediate for a given operand width
   function automatic int wide_bits(input int w);
      return 2 * w + 1;
   endfunction

endpackage

// File: rtl/fxp_mul_scale.sv
module fxp_mul_scale #(
   parameter int WIDTH = 8,
   parameter int FRAC  = 3,
   localparam int IW   = fxp_mul_pkg::wide_bits(WIDTH)
) (
   input  logic signed [WIDTH-1:0] a,
   input  logic signed [WIDTH-1:0] b,
   output logic signed [IW-1:0]    trunc_q,
   output logic signed [IW-1:0]    round_q
);
   localparam int PW = 2 * WIDTH;

   logic signed [PW-1:0] prod;
   logic signed [IW-1:0] prod_x;

   always_comb begin
      prod   = a * b;
      prod_x = IW'(prod);
   end

   generate
      if (FRAC == 0) begin : g_integer
         always_comb begin
            trunc_q = prod_x;
            round_q = prod_x;
         end
      end else begin : g_fraction
         localparam logic signed [IW-1:0] HALF = IW'(1) << (FRAC - 1);
         logic signed [IW-1:0] biased;
         always_comb begin
            biased  = prod_x + HALF;
            trunc_q = prod_x >>> FRAC;
            round_q = biased >>> FRAC;
         end
      end
   endgenerate

endmodule

// File: rtl/fxp_mul_limit.sv
module fxp_mul_limit #(
   parameter int WIDTH = 8,
   localparam int IW   = fxp_mul_pkg::wide_bits(WIDTH)
) (
   input  logic signed [IW-1:0]    val,
   input  logic                    clamp_en,
   output logic signed [WIDTH-1:0] q,
   output logic                    out_of_range
);
   localparam logic signed [WIDTH-1:0] TOP    = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic signed [WIDTH-1:0] BOTTOM = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic signed [IW-1:0]    TOP_X  = IW'(TOP);
   localparam logic signed [IW-1:0]    BOT_X  = IW'(BOTTOM);

   logic above, below;

   always_comb begin
      above        = val > TOP_X;
      below        = val < BOT_X;
      out_of_range = above | below;
      if (clamp_en && above)      q = TOP;
      else if (clamp_en && below) q = BOTTOM;
      else                        q = val[WIDTH-1:0];
   end

endmodule

// File: rtl/fxp_mul_rs.sv
module fxp_mul_rs #(
   parameter int WIDTH = 8,
   parameter int FRAC  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [WIDTH-1:0] a,
   input  logic signed [WIDTH-1:0] b,
   input  logic                    round_en,
   input  logic                    sat_en,
   output logic                    out_valid,
   output logic signed [WIDTH-1:0] result,
   output logic                    ovf
);
   import fxp_mul_pkg::*;

   localparam int IW = wide_bits(WIDTH);
   localparam logic signed [WIDTH-1:0] TOP    = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic signed [WIDTH-1:0] BOTTOM = {1'b1, {(WIDTH-1){1'b0}}};

   // R10: format legality
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fxp_mul_rs: WIDTH must be at least 2");
      end
      if (FRAC < 0 || FRAC >= WIDTH) begin : g_bad_frac
         $error("fxp_mul_rs: FRAC must lie in [0, WIDTH-1]");
      end
   endgenerate

   logic signed [IW-1:0]    trunc_q, round_q, scaled;
   logic signed [WIDTH-1:0] limited;
   logic                    range_hit;
   rnd_mode_e               rmode;
   ovf_mode_e               omode;

   always_comb begin
      rmode  = rnd_mode_e'(round_en);
      omode  = ovf_mode_e'(sat_en);
      scaled = (rmode == RND_NEAREST) ? round_q : trunc_q;
   end

   fxp_mul_scale #(.WIDTH(WIDTH), .FRAC(FRAC)) u_scale (
      .a       (a),
      .b       (b),
      .trunc_q (trunc_q),
      .round_q (round_q)
   );

   fxp_mul_limit #(.WIDTH(WIDTH)) u_limit (
      .val          (scaled),
      .clamp_en     (omode == OVF_CLAMP),
      .q            (limited),
      .out_of_range (range_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ovf       <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= limited;
            ovf    <= range_hit;
         end
      end
   end

   // R2: one-cycle strobe
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9: outputs hold without a strobe
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(ovf)));

   // R4: rounding adds at most one LSB over truncation
   p_round_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ((round_q - trunc_q) == 0 || (round_q - trunc_q) == 1));

   // R5/R6: a clamped result sits on a rail
   p_sat_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ovf && $past(sat_en)) |-> (result == TOP || result == BOTTOM));

endmodule

// File: tb/tb_fxp_mul_rs.sv
module tb_fxp_mul_rs;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 8;
   localparam int F  = 3;
   localparam int W2 = 6;
   localparam int F2 = 0;

   typedef struct packed {
      logic signed [7:0] a;
      logic signed [7:0] b;
      logic              rnd;
      logic              sat;
      logic signed [7:0] exp_res;
      logic              exp_ovf;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{ 8'sd25,   8'sd20,  1'b0, 1'b1,  8'sd62,  1'b0},  // R3 .5 dropped
      '{ 8'sd25,   8'sd20,  1'b1, 1'b1,  8'sd63,  1'b0},  // R4 .5 rounds up
      '{-8'sd25,   8'sd20,  1'b0, 1'b1, -8'sd63,  1'b0},  // R3 toward -inf
      '{-8'sd25,   8'sd20,  1'b1, 1'b1, -8'sd62,  1'b0},  // R4
      '{ 8'sd25,   8'sd19,  1'b0, 1'b1,  8'sd59,  1'b0},  // R3 475>>3
      '{ 8'sd100,  8'sd100, 1'b0, 1'b1,  8'sd127, 1'b1},  // R5
      '{ 8'sd100,  8'sd100, 1'b0, 1'b0, -8'sd30,  1'b1},  // R7 1250 wraps
      '{-8'sd100,  8'sd100, 1'b0, 1'b1, -8'sd128, 1'b1},  // R6
      '{-8'sd100,  8'sd100, 1'b0, 1'b0,  8'sd30,  1'b1},  // R7
      '{-8'sd128, -8'sd128, 1'b0, 1'b1,  8'sd127, 1'b1},  // R5 min squared
      '{-8'sd128, -8'sd128, 1'b1, 1'b0,  8'sd0,   1'b1},  // R7 min squared
      '{-8'sd128,  8'sd127, 1'b0, 1'b1, -8'sd128, 1'b1},  // R6
      '{ 8'sd127,  8'sd8,   1'b0, 1'b1,  8'sd127, 1'b0},  // R8 top rail exact
      '{ 8'sd102,  8'sd10,  1'b0, 1'b1,  8'sd127, 1'b0},  // R8 127.5 truncated
      '{ 8'sd102,  8'sd10,  1'b1, 1'b1,  8'sd127, 1'b1},  // R5 rounding overflows
      '{ 8'sd102,  8'sd10,  1'b1, 1'b0, -8'sd128, 1'b1},  // R7 rounding wraps
      '{-8'sd128,  8'sd8,   1'b0, 1'b0, -8'sd128, 1'b0},  // R8 bottom rail exact
      '{ 8'sd0,   -8'sd77,  1'b1, 1'b1,  8'sd0,   1'b0},  // R8 zero
      '{-8'sd1,    8'sd4,   1'b0, 1'b1, -8'sd1,   1'b0},  // R3 small negative
      '{-8'sd1,    8'sd4,   1'b1, 1'b1,  8'sd0,   1'b0},  // R4 -0.5 rounds up
      '{ 8'sd8,    8'sd8,   1'b1, 1'b0,  8'sd8,   1'b0}   // R8 1.0*1.0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0]  a = '0, b = '0;
   logic signed [W2-1:0] a2 = '0, b2 = '0;
   logic round_en = 1'b0, sat_en = 1'b0;
   logic out_valid, ovf, out_valid2, ovf2;
   logic signed [W-1:0]  result;
   logic signed [W2-1:0] result2;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fxp_mul_rs #(.WIDTH(W), .FRAC(F)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
      .round_en(round_en), .sat_en(sat_en),
      .out_valid(out_valid), .result(result), .ovf(ovf));

   fxp_mul_rs #(.WIDTH(W2), .FRAC(F2)) dut_int (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a2), .b(b2),
      .round_en(round_en), .sat_en(sat_en),
      .out_valid(out_valid2), .result(result2), .ovf(ovf2));

   function automatic void model(input longint x, input longint y, input int w,
                                 input int f, input bit rnd, input bit sat,
                                 output longint res, output bit ov);
      longint p, s, hi, lo, m;
      p = x * y;
      if (rnd && f > 0) p = p + (longint'(1) << (f - 1));
      s  = p >>> f;
      hi = (longint'(1) << (w - 1)) - 1;
      lo = -(longint'(1) << (w - 1));
      ov = (s > hi) || (s < lo);
      m  = s & ((longint'(1) << w) - 1);
      if (m > hi) m = m - (longint'(1) << w);
      if (sat && s > hi)      res = hi;
      else if (sat && s < lo) res = lo;
      else                    res = m;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // drive one strobe, then sample the registered outputs at the next falling edge
   task automatic strobe();
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      longint er;
      bit     eo;
      // R1: reset state
      @(negedge clk);
      check("R1 out_valid", out_valid, 0);
      check("R1 result", result, 0);
      check("R1 ovf", ovf, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-release out_valid", out_valid, 0);
      check("R1 post-release result", result, 0);

      // table walk (R3..R8)
      for (int i = 0; i < NV; i++) begin
         a = VECS[i].a; b = VECS[i].b;
         round_en = VECS[i].rnd; sat_en = VECS[i].sat;
         strobe();
         check("R2 out_valid", out_valid, 1);
         check("R3-R8 table result", result, VECS[i].exp_res);
         check("R5-R8 table ovf", ovf, VECS[i].exp_ovf);
      end

      // R9 and R2: no strobe, operands move, outputs hold
      a = 8'sd100; b = 8'sd100; round_en = 1'b0; sat_en = 1'b1;
      @(negedge clk);
      check("R2 idle out_valid", out_valid, 0);
      check("R9 result held", result, 8);
      check("R9 ovf held", ovf, 0);
      @(negedge clk);
      check("R9 result still held", result, 8);

      // random against the model, both instances
      for (int i = 0; i < 400; i++) begin
         a  = W'($urandom);  b  = W'($urandom);
         a2 = W2'($urandom); b2 = W2'($urandom);
         round_en = 1'($urandom); sat_en = 1'($urandom);
         strobe();
         model(a, b, W, F, round_en, sat_en, er, eo);
         check("R3/R4 random result", result, er);
         check("R5-R8 random ovf", ovf, eo);
         model(a2, b2, W2, F2, round_en, sat_en, er, eo);
         check("R4 integer-format result", result2, er);
         check("R7 integer-format ovf", ovf2, eo);
         check("R2 integer-format out_valid", out_valid2, 1);
      end

      // R1: reset in mid-run clears state
      a = 8'sd100; b = 8'sd100; sat_en = 1'b1;
      strobe();
      rst_n = 1'b0;
      #1;
      check("R1 async clear result", result, 0);
      check("R1 async clear ovf", ovf, 0);
      finish_run();
   end

endmodule